// File: doc/BRIEF.md
# Cell Voltage Averaging Sequencer

This block sits between a battery-voltage ADC and the voltage register of a fuel-gauge controller. It accepts a stream of conversion samples, each qualified by a valid strobe, and averages them over timed windows. The windows are measured in ticks of a 32 kHz time base. At the end of each window the block publishes a 12-bit average into a 16-bit register. The average sits left-justified in the register, with the bottom four bits held at zero. A one-cycle strobe tells the register block and the state-of-charge logic that a new value is ready.

The first window after reset, or after a quick-start, is short: 4096 ticks by default, which is 125 ms. Every later window is long: 16384 ticks, which is 500 ms. Each window averages a fixed power-of-two number of samples, so the division is a right shift. Samples that arrive after that number is reached are dropped. Missing samples count as zero. The register LSB stands for 1.25 mV in a single-cell system (0 to 5.00 V) and 2.5 mV in a dual-cell system (0 to 10 V); the block itself is the same in both.

A halt input from the mode controller freezes the window timer and the accumulator. The sequence resumes from the same point when halt is released. A quick-start discards the partial window and starts again with a short window. It leaves the published value in place.

Top module: `vcell_avg_seq`

## Requirements
- R1: After reset, vcell_o reads 0 and vcell_upd_o is low.
- R2: The first window after reset or quick-start closes on its SHORT_TICKS-th accepted tick. A tick is accepted when tick_i is high and both halt_i and qstart_i are low. vcell_upd_o is high for exactly the one cycle after the closing tick.
- R3: Every window after the first closes on its LONG_TICKS-th accepted tick, with the same one-cycle update strobe.
- R4: The published average is the sum of the first 2^SHORT_LOG2 (first window) or 2^LONG_LOG2 (later windows) valid samples of the window, shifted right by that log2. A sample whose valid coincides with the closing tick belongs to the closing window. Samples beyond the quota are ignored, and missing samples count as zero.
- R5: The average occupies vcell_o[15:4], and vcell_o[3:0] always reads 0.
- R6: vcell_o changes only in the cycle in which vcell_upd_o is high.
- R7: While halt_i is high, ticks and samples are ignored and no update occurs. Counting resumes from the frozen point afterwards.
- R8: qstart_i (which takes priority over halt_i) discards the partial window's ticks and samples, restarts with a short window, and keeps vcell_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 32 kHz time-base strobe |
| qstart_i | input | 1 | Quick-start: restart the sequence with a short window |
| halt_i | input | 1 | Freeze timer and accumulator |
| sample_vld_i | input | 1 | ADC sample valid |
| sample_i | input | 12 | ADC sample code |
| vcell_o | output | 16 | Voltage register: average in 15:4, zeros in 3:0 |
| vcell_upd_o | output | 1 | One-cycle strobe on a register update |

## Verification
The hardest cases sit at the edge of a window: a window that closes with its sample quota only partly filled, and halt or quick-start arriving in the same cycle as the tick that would close the window. The bench shrinks the windows to a few ticks and sweeps every combination of tick spacing and sample spacing. This makes quota overflow, quota shortfall and a sample on the closing tick all occur within a few windows. Halt and quick-start pulses are then placed on fixed cycle offsets so that they land on closing ticks and inside long windows.

// File: rtl/vavg_pkg.sv
package vavg_pkg;
  typedef enum logic {
    WIN_SHORT = 1'b0,
    WIN_LONG  = 1'b1
  } win_kind_e;
endpackage

// File: rtl/vavg_window_timer.sv
module vavg_window_timer
  import vavg_pkg::*;
#(
  parameter int SHORT_TICKS = 4096,
  parameter int LONG_TICKS  = 16384
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      hold_i,
  input  logic      restart_i,
  output logic      win_end_o,
  output win_kind_e kind_o
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  win_kind_e        kind_q;
  logic             accept;
  logic             at_last;

  assign accept    = tick_i && !hold_i && !restart_i;
  assign at_last   = (kind_q == WIN_LONG) ? (cnt_q == LONG_LAST) : (cnt_q == SHORT_LAST);
  assign win_end_o = accept && at_last;
  assign kind_o    = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= WIN_SHORT;
    end else if (restart_i) begin
      cnt_q  <= '0;
      kind_q <= WIN_SHORT;
    end else if (accept) begin
      if (at_last) begin
        cnt_q  <= '0;
        kind_q <= WIN_LONG;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vavg_accum.sv
module vavg_accum
  import vavg_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                hold_i,
  input  logic                restart_i,
  input  logic                win_end_i,
  input  win_kind_e           kind_i,
  output logic [SAMPLE_W-1:0] avg_o
);
  localparam int MAX_LOG2 = (LONG_LOG2 > SHORT_LOG2) ? LONG_LOG2 : SHORT_LOG2;
  localparam int ACC_W    = SAMPLE_W + MAX_LOG2;
  localparam int N_W      = MAX_LOG2 + 1;
  localparam logic [N_W-1:0] SHORT_QUOTA = N_W'(1 << SHORT_LOG2);
  localparam logic [N_W-1:0] LONG_QUOTA  = N_W'(1 << LONG_LOG2);

  logic [ACC_W-1:0] acc_q;
  logic [N_W-1:0]   n_q;
  logic [N_W-1:0]   quota;
  logic             take;
  logic [ACC_W-1:0] sum_full;

  assign quota    = (kind_i == WIN_LONG) ? LONG_QUOTA : SHORT_QUOTA;
  assign take     = sample_vld_i && !hold_i && !restart_i && (n_q < quota);
  assign sum_full = take ? (acc_q + ACC_W'(sample_i)) : acc_q;
  // power-of-two sample count: division is a shift
  assign avg_o    = (kind_i == WIN_LONG) ? SAMPLE_W'(sum_full >> LONG_LOG2)
                                         : SAMPLE_W'(sum_full >> SHORT_LOG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (restart_i || win_end_i) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (take) begin
      acc_q <= sum_full;
      n_q   <= n_q + 1'b1;
    end
  end
endmodule

// File: rtl/vavg_result_reg.sv
module vavg_result_reg #(
  parameter int SAMPLE_W = 12,
  parameter int REG_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] avg_i,
  output logic [REG_W-1:0]    vcell_o,
  output logic                upd_o
);
  localparam int PAD_W = REG_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] val_q;
  logic                upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) val_q <= avg_i;
    end
  end

  assign vcell_o = {val_q, {PAD_W{1'b0}}};
  assign upd_o   = upd_q;
endmodule

// File: rtl/vcell_avg_seq.sv
module vcell_avg_seq
  import vavg_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int REG_W       = 16,
  parameter int SHORT_TICKS = 4096,
  parameter int LONG_TICKS  = 16384,
  parameter int SHORT_LOG2  = 5,
  parameter int LONG_LOG2   = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                qstart_i,
  input  logic                halt_i,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [REG_W-1:0]    vcell_o,
  output logic                vcell_upd_o
);
  logic                win_end;
  win_kind_e           kind;
  logic [SAMPLE_W-1:0] avg;

  vavg_window_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .hold_i   (halt_i),
    .restart_i(qstart_i),
    .win_end_o(win_end),
    .kind_o   (kind)
  );

  vavg_accum #(
    .SAMPLE_W  (SAMPLE_W),
    .SHORT_LOG2(SHORT_LOG2),
    .LONG_LOG2 (LONG_LOG2)
  ) accum_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_vld_i(sample_vld_i),
    .sample_i    (sample_i),
    .hold_i      (halt_i),
    .restart_i   (qstart_i),
    .win_end_i   (win_end),
    .kind_i      (kind),
    .avg_o       (avg)
  );

  vavg_result_reg #(
    .SAMPLE_W(SAMPLE_W),
    .REG_W   (REG_W)
  ) result_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (win_end),
    .avg_i  (avg),
    .vcell_o(vcell_o),
    .upd_o  (vcell_upd_o)
  );
endmodule

// File: rtl/vavg_checker.sv
module vavg_checker #(
  parameter int SHORT_TICKS = 4096,
  parameter int LONG_TICKS  = 16384,
  parameter int REG_W       = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             qstart_i,
  input logic             halt_i,
  input logic [REG_W-1:0] vcell_o,
  input logic             vcell_upd_o
);
  int   seen_q;
  logic long_q;
  logic accept;
  logic closing;

  assign accept  = tick_i && !halt_i && !qstart_i;
  assign closing = accept && (seen_q == (long_q ? LONG_TICKS : SHORT_TICKS) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 0;
      long_q <= 1'b0;
    end else if (qstart_i) begin
      seen_q <= 0;
      long_q <= 1'b0;
    end else if (closing) begin
      seen_q <= 0;
      long_q <= 1'b1;
    end else if (accept) begin
      seen_q <= seen_q + 1;
    end
  end

  assert_short_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closing && !long_q) |=> vcell_upd_o);
  assert_long_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closing && long_q) |=> vcell_upd_o);
  assert_no_stray_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closing |=> !vcell_upd_o);
  assert_low_nibble_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcell_o[3:0] == 4'h0);
  assert_hold_between_updates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcell_upd_o |-> $stable(vcell_o));
  assert_halt_blocks_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !qstart_i) |=> !vcell_upd_o);
  assert_qstart_blocks_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qstart_i |=> !vcell_upd_o);
endmodule

bind vcell_avg_seq vavg_checker #(
  .SHORT_TICKS(SHORT_TICKS),
  .LONG_TICKS (LONG_TICKS),
  .REG_W      (REG_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .qstart_i   (qstart_i),
  .halt_i     (halt_i),
  .vcell_o    (vcell_o),
  .vcell_upd_o(vcell_upd_o)
);

// File: tb/vcell_avg_seq_tb.sv
module vcell_avg_seq_tb_top;
  localparam int SW = 12;
  localparam int RW = 16;
  localparam int ST = 8;
  localparam int LT = 20;
  localparam int SL = 2;
  localparam int LL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, qs = 1'b0, hlt = 1'b0, vld = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [RW-1:0] vcell;
  logic          upd;

  int n_chk = 0;
  int n_fail = 0;

  // expected-state model built from the requirements
  int  m_cnt = 0, m_n = 0, m_sum = 0, m_reg = 0;
  bit  m_long = 0, m_upd = 0;

  always #2.5 clk = ~clk;

  vcell_avg_seq #(
    .SAMPLE_W(SW), .REG_W(RW), .SHORT_TICKS(ST), .LONG_TICKS(LT),
    .SHORT_LOG2(SL), .LONG_LOG2(LL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .qstart_i(qs), .halt_i(hlt),
    .sample_vld_i(vld), .sample_i(smp), .vcell_o(vcell), .vcell_upd_o(upd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit t, input bit v, input int s,
                      input bit h, input bit q);
    int lim, quota, k, fin;
    bit take;
    @(negedge clk);
    tick = t; vld = v; smp = SW'(s); hlt = h; qs = q;
    lim   = m_long ? LT : ST;
    k     = m_long ? LL : SL;
    quota = 1 << k;
    m_upd = 0;
    if (q) begin
      m_cnt = 0; m_n = 0; m_sum = 0; m_long = 0;
    end else if (!h) begin
      take = v && (m_n < quota);
      fin  = m_sum + (take ? s : 0);
      if (t && m_cnt == lim - 1) begin
        m_reg = (fin >> k) << 4;
        m_upd = 1;
        m_cnt = 0; m_n = 0; m_sum = 0; m_long = 1;
      end else begin
        m_sum = fin;
        if (take) m_n++;
        if (t) m_cnt++;
      end
    end
    @(posedge clk);
    #1;
    chk({tag, " vcell"}, int'(vcell), m_reg);
    chk({tag, " upd"}, int'(upd), int'(m_upd));
    chk("R5 low nibble", int'(vcell[3:0]), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vcell", int'(vcell), 0);
    chk("R1 reset upd", int'(upd), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4: sweep tick spacing vs sample spacing
    for (int tp = 1; tp <= 3; tp++) begin
      for (int vp = 1; vp <= 5; vp++) begin
        step("R2 R3 R4 restart", 0, 0, 0, 0, 1);
        for (int c = 0; c < (ST + 2 * LT) * tp + 3; c++)
          step("R2 R3 R4 sweep", (c % tp) == 0, (c % vp) == 0,
               (c * 37 + tp * 411 + vp * 97) % 4096, 0, 0);
      end
    end

    // R4 R5: full-scale samples
    step("R4 restart", 0, 0, 0, 0, 1);
    for (int c = 0; c < ST + LT + 2; c++)
      step("R4 R5 full scale", 1, 1, 4095, 0, 0);

    // R7: halt pulses, samples offered during halt must be ignored
    step("R7 restart", 0, 0, 0, 0, 1);
    for (int c = 0; c < 3 * (ST + LT); c++)
      step("R7 halt", 1, 1, (c % 5 == 2 || c % 5 == 3) ? 4095 : (c * 13) % 512,
           (c % 5 == 2) || (c % 5 == 3), 0);

    // R7: halt on every closing tick candidate
    for (int c = 0; c < 2 * LT; c++)
      step("R7 halt at boundary", 1, 1, 300 + c, (c % 4) == 3, 0);

    // R8: quick-start mid long window, keeps published value
    for (int c = 0; c < ST + LT / 2; c++)
      step("R8 pre", 1, 1, 1000 + c, 0, 0);
    step("R8 quick-start", 1, 1, 4095, 0, 1);
    for (int c = 0; c < ST + LT + 2; c++)
      step("R8 short again", 1, 1, 2000 + 3 * c, 0, 0);

    // R8: quick-start while halted wins
    for (int c = 0; c < 5; c++) step("R8 pre halt", 1, 1, 50, 0, 0);
    step("R8 halted", 1, 1, 4000, 1, 0);
    step("R8 qstart in halt", 1, 1, 4000, 1, 1);
    for (int c = 0; c < ST + 2; c++)
      step("R8 after", 1, (c % 2) == 0, 700 + c, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule